// File: doc/BRIEF.md
# Indexed Block Configuration Register Slave

This block is a two-wire serial slave that gives a host access to a bank of fifteen 8-bit configuration registers. The host first picks a register with an index byte and then moves a block of bytes in or out, with the register pointer moving up by one after each byte. The block samples the serial clock and data lines with a fast system clock. It drives the data line only through an open-drain pull-low enable. The rest of the chip sees every register at all times on a flat parallel bus. Each register update also raises a one-cycle write strobe that carries the register number.

A block write is: start, address byte 0xD2, index N, count X, then data bytes. The first X data bytes land in registers N onward. A block read starts the same way up to the index. The host then sends a repeated start and address byte 0xD3. The slave answers with the read-length byte held in register 8, then with register contents from N upward, for as long as the host acknowledges.

Top module: `smbus_cfg_slave`

## Requirements
- R1: After reset, registers 1 and 2 read 0xFF, register 8 reads 0x0F, register 9 reads 0x07, and all other registers read 0x00. Register i appears on `cfgRegs[8*i+7:8*i]`.
- R2: The slave acknowledges address byte 0xD2 (write) and 0xD3 (read). It leaves any other address byte unacknowledged and ignores the rest of that transaction.
- R3: In a block write, the slave acknowledges the index byte, the count byte and each data byte. Data byte k (counting from 0, with k < X) is stored at register N+k. Each stored byte gives one `wrStrobe` pulse, with `wrIndex` set to that register.
- R4: Data bytes beyond the count X are acknowledged, change no register and raise no strobe.
- R5: A data byte addressed to an index of 15 or above is acknowledged and discarded, with no strobe.
- R6: In a block read, the first byte returned is the value of register 8. The bytes that follow are registers N, N+1 and so on. The pointer advances after every byte the host acknowledges, and a host NACK ends the transfer.
- R7: A read from an index of 15 or above returns 0xFF.
- R8: Bit 5 of register 10 is read-only. It stays 0, and writes to register 10 change only its other bits.
- R9: The slave changes its data pull-low only while the filtered clock is low. It releases the data line once a stop is seen.
- R10: A pulse on either line that lasts fewer than `FILT_LEN` system clocks after synchronisation is ignored. It neither adds a clock edge nor makes a start or stop.
- R11: A start or stop seen partway through a byte discards the partial byte. After a stop, clocked bytes are ignored until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample both serial lines |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Serial clock line as seen at the pad |
| sdaIn | input | 1 | Serial data line as seen at the pad |
| sdaPullLow | output | 1 | Open-drain enable; 1 pulls the data line low |
| cfgRegs | output | NUM_REGS*8 | All registers, register i in bits 8*i+7..8*i |
| wrStrobe | output | 1 | One-cycle pulse for each register update |
| wrIndex | output | IDX_W | Register number that goes with `wrStrobe` |

## Verification
Block writes are sent with a count equal to, smaller than and running past the end of the bank. This separates correct storage from over-count handling and from out-of-range handling. Reads start in the middle of the bank and near its end, and one read follows a change to the count register. These show that the count byte comes first and that 0xFF fills the space past the last register. Clock and data glitches are injected inside a byte, and some transactions are cut off by a start or stop partway through a byte. These show that the filter and the abort handling reject false edges but keep real framing.

// File: rtl/smbcfg_pkg.sv
package smbcfg_pkg;

  localparam int REG_COUNT_IDX = 8;
  localparam int REG_ALARM_IDX = 10;
  localparam int REG_ALARM_BIT = 5;

  typedef enum logic [1:0] {ST_IDLE, ST_RX, ST_TX} busState_t;
  typedef enum logic [1:0] {RL_ADDR, RL_INDEX, RL_COUNT, RL_DATA} rxRole_t;

  typedef struct packed {
    logic       setIndex;
    logic       storeByte;
    logic       advance;
    logic [7:0] byteVal;
  } dpStrobe_t;

  function automatic logic [7:0] regResetValue(input int idx);
    case (idx)
      1, 2:          return 8'hFF;
      REG_COUNT_IDX: return 8'h0F;
      9:             return 8'h07;
      default:       return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] regKeepMask(input int idx);
    if (idx == REG_ALARM_IDX) return 8'(1 << REG_ALARM_BIT);
    return 8'h00;
  endfunction

endpackage

// File: rtl/smb_line_filter.sv
module smb_line_filter #(
  parameter int FILT_LEN = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic lineIn,
  output logic lineLvl,
  output logic lineRise,
  output logic lineFall
);
  localparam int CNT_W = $clog2(FILT_LEN + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FILT_LEN - 1);

  logic [1:0]       syncQ;
  logic [CNT_W-1:0] runCnt;
  logic             levelQ;
  logic             levelDly;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ    <= 2'b11;
      runCnt   <= '0;
      levelQ   <= 1'b1;
      levelDly <= 1'b1;
    end else begin
      syncQ    <= {syncQ[0], lineIn};
      levelDly <= levelQ;
      if (syncQ[1] != levelQ) begin
        if (runCnt == CNT_LAST) begin
          levelQ <= syncQ[1];
          runCnt <= '0;
        end else begin
          runCnt <= runCnt + 1'b1;
        end
      end else begin
        runCnt <= '0;
      end
    end
  end

  assign lineLvl  = levelQ;
  assign lineRise = levelQ & ~levelDly;
  assign lineFall = ~levelQ & levelDly;

  // R10
  filter_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(levelQ) |-> (syncQ[1] == levelQ));

endmodule

// File: rtl/smb_ctrl.sv
module smb_ctrl
  import smbcfg_pkg::*;
#(
  parameter logic [7:0] WR_ADDR = 8'hD2,
  parameter logic [7:0] RD_ADDR = 8'hD3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclLvl,
  input  logic       sclRise,
  input  logic       sclFall,
  input  logic       sdaLvl,
  input  logic       sdaRise,
  input  logic       sdaFall,
  input  logic [7:0] readByte,
  input  logic [7:0] countByte,
  output dpStrobe_t  dpStb,
  output logic       sdaPullLow
);
  busState_t  state;
  rxRole_t    role;
  logic [3:0] bitCnt;
  logic       inAck;
  logic       ackDrive;
  logic       txPend;
  logic       hostAck;
  logic [7:0] shiftQ;
  logic [7:0] remain;

  logic startDet, stopDet;
  assign startDet = sclLvl & sdaFall;
  assign stopDet  = sclLvl & sdaRise;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      role     <= RL_ADDR;
      bitCnt   <= '0;
      inAck    <= 1'b0;
      ackDrive <= 1'b0;
      txPend   <= 1'b0;
      hostAck  <= 1'b0;
      shiftQ   <= 8'hFF;
      remain   <= '0;
      dpStb    <= '0;
    end else begin
      dpStb <= '0;
      if (stopDet) begin
        state    <= ST_IDLE;
        ackDrive <= 1'b0;
        inAck    <= 1'b0;
        txPend   <= 1'b0;
      end else if (startDet) begin
        state    <= ST_RX;
        role     <= RL_ADDR;
        bitCnt   <= '0;
        inAck    <= 1'b0;
        ackDrive <= 1'b0;
        txPend   <= 1'b0;
      end else begin
        case (state)
          ST_RX: begin
            if (sclRise && !inAck && bitCnt < 4'd8) begin
              shiftQ <= {shiftQ[6:0], sdaLvl};
              bitCnt <= bitCnt + 4'd1;
            end else if (sclFall && !inAck && bitCnt == 4'd8) begin
              inAck    <= 1'b1;
              ackDrive <= 1'b1;
              case (role)
                RL_ADDR: begin
                  if (shiftQ == WR_ADDR) begin
                    role <= RL_INDEX;
                  end else if (shiftQ == RD_ADDR) begin
                    txPend <= 1'b1;
                  end else begin
                    ackDrive <= 1'b0;
                    inAck    <= 1'b0;
                    state    <= ST_IDLE;
                  end
                end
                RL_INDEX: begin
                  dpStb.setIndex <= 1'b1;
                  dpStb.byteVal  <= shiftQ;
                  role           <= RL_COUNT;
                end
                RL_COUNT: begin
                  remain <= shiftQ;
                  role   <= RL_DATA;
                end
                default: begin
                  if (remain != 8'd0) begin
                    dpStb.storeByte <= 1'b1;
                    dpStb.byteVal   <= shiftQ;
                    remain          <= remain - 8'd1;
                  end
                end
              endcase
            end else if (sclFall && inAck) begin
              inAck    <= 1'b0;
              ackDrive <= 1'b0;
              bitCnt   <= '0;
              if (txPend) begin
                txPend <= 1'b0;
                state  <= ST_TX;
                shiftQ <= countByte;
              end
            end
          end
          ST_TX: begin
            if (sclFall && bitCnt < 4'd8) begin
              shiftQ <= {shiftQ[6:0], 1'b1};
              bitCnt <= bitCnt + 4'd1;
            end else if (sclRise && bitCnt == 4'd8) begin
              hostAck <= ~sdaLvl;
            end else if (sclFall && bitCnt == 4'd8) begin
              if (hostAck) begin
                shiftQ        <= readByte;
                dpStb.advance <= 1'b1;
                bitCnt        <= '0;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sdaPullLow = ackDrive | ((state == ST_TX) && (bitCnt < 4'd8) && !shiftQ[7]);

  // R9
  sda_change_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaPullLow) |-> !sclLvl);

  // R9
  stop_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    stopDet |=> !sdaPullLow);

endmodule

// File: rtl/smb_regbank.sv
module smb_regbank
  import smbcfg_pkg::*;
#(
  parameter int NUM_REGS = 15,
  parameter int IDX_W    = $clog2(NUM_REGS)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  dpStrobe_t             dpStb,
  output logic [7:0]            readByte,
  output logic [7:0]            countByte,
  output logic [NUM_REGS*8-1:0] regFlat,
  output logic                  wrStrobe,
  output logic [IDX_W-1:0]      wrIndex
);
  localparam logic [7:0] PTR_END = 8'(NUM_REGS);

  logic [7:0] ptrQ;
  logic       inRange;
  assign inRange = ptrQ < PTR_END;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    localparam logic [7:0] KEEP = regKeepMask(i);
    logic [7:0] regVal;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) regVal <= regResetValue(i);
      else if (dpStb.storeByte && ptrQ == 8'(i))
        regVal <= (dpStb.byteVal & ~KEEP) | (regVal & KEEP);
    end
    assign regFlat[i*8 +: 8] = regVal;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptrQ     <= '0;
      wrStrobe <= 1'b0;
      wrIndex  <= '0;
    end else begin
      wrStrobe <= dpStb.storeByte && inRange;
      wrIndex  <= ptrQ[IDX_W-1:0];
      if (dpStb.setIndex) ptrQ <= dpStb.byteVal;
      else if ((dpStb.storeByte || dpStb.advance) && ptrQ != 8'hFF) ptrQ <= ptrQ + 8'd1;
    end
  end

  assign readByte  = inRange ? regFlat[ptrQ[IDX_W-1:0]*8 +: 8] : 8'hFF;
  assign countByte = regFlat[REG_COUNT_IDX*8 +: 8];

  // R8
  ro_bit_chk: assert property (@(posedge clk) disable iff (!rstN)
    $stable(regFlat[REG_ALARM_IDX*8 + REG_ALARM_BIT]));

  // R5
  wr_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe |-> (32'(wrIndex) < NUM_REGS));

  // R3
  wr_lands_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dpStb.storeByte && inRange) |=> wrStrobe);

endmodule

// File: rtl/smbus_cfg_slave.sv
module smbus_cfg_slave
  import smbcfg_pkg::*;
#(
  parameter int         NUM_REGS = 15,
  parameter int         FILT_LEN = 3,
  parameter logic [7:0] WR_ADDR  = 8'hD2,
  parameter int         IDX_W    = $clog2(NUM_REGS)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  sclIn,
  input  logic                  sdaIn,
  output logic                  sdaPullLow,
  output logic [NUM_REGS*8-1:0] cfgRegs,
  output logic                  wrStrobe,
  output logic [IDX_W-1:0]      wrIndex
);
  localparam logic [7:0] RD_ADDR = WR_ADDR | 8'h01;

  logic [1:0] rawLines, lineLvl, lineRise, lineFall;
  assign rawLines = {sdaIn, sclIn};

  for (genvar l = 0; l < 2; l++) begin : g_line
    smb_line_filter #(.FILT_LEN(FILT_LEN)) u_flt (
      .clk(clk), .rstN(rstN), .lineIn(rawLines[l]),
      .lineLvl(lineLvl[l]), .lineRise(lineRise[l]), .lineFall(lineFall[l]));
  end

  dpStrobe_t  dpStb;
  logic [7:0] readByte, countByte;

  smb_ctrl #(.WR_ADDR(WR_ADDR), .RD_ADDR(RD_ADDR)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .sclLvl(lineLvl[0]), .sclRise(lineRise[0]), .sclFall(lineFall[0]),
    .sdaLvl(lineLvl[1]), .sdaRise(lineRise[1]), .sdaFall(lineFall[1]),
    .readByte(readByte), .countByte(countByte),
    .dpStb(dpStb), .sdaPullLow(sdaPullLow));

  smb_regbank #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_bank (
    .clk(clk), .rstN(rstN), .dpStb(dpStb),
    .readByte(readByte), .countByte(countByte), .regFlat(cfgRegs),
    .wrStrobe(wrStrobe), .wrIndex(wrIndex));

endmodule

// File: tb/sim_smbus_cfg_slave.sv
`timescale 1ns/1ps
module sim_smbus_cfg_slave;
  localparam int Q = 10;
  localparam int NR = 15;

  logic clk = 1'b0, rstN = 1'b0;
  logic sclDrv = 1'b1, sdaDrv = 1'b1;
  logic sdaPullLow, wrStrobe;
  logic [NR*8-1:0] cfgRegs;
  logic [3:0] wrIndex;
  wire sdaLine = sdaDrv & ~sdaPullLow;

  always #2 clk = ~clk;

  smbus_cfg_slave u0 (.clk(clk), .rstN(rstN), .sclIn(sclDrv), .sdaIn(sdaLine),
    .sdaPullLow(sdaPullLow), .cfgRegs(cfgRegs), .wrStrobe(wrStrobe), .wrIndex(wrIndex));

  int checks = 0, failures = 0;
  bit done = 1'b0, cmpEn = 1'b0;
  int expRegs [NR];
  int strobeQ [$];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // reference register image compared with the bus on every idle clock (R3 R4 R5 R8)
  always @(negedge clk) begin
    if (rstN && cmpEn) begin
      int bad = -1;
      for (int i = 0; i < NR; i++)
        if (int'(cfgRegs[i*8 +: 8]) != expRegs[i]) bad = i;
      checks++;
      if (bad >= 0) begin
        failures++;
        $display("FAIL R3 register image reg%0d actual=%0h expected=%0h",
                 bad, cfgRegs[bad*8 +: 8], expRegs[bad]);
      end
    end
    if (rstN && wrStrobe) strobeQ.push_back(int'(wrIndex));
  end

  task automatic doStart();
    sdaDrv = 1'b1; tick(Q); sclDrv = 1'b1; tick(Q);
    sdaDrv = 1'b0; tick(Q); sclDrv = 1'b0; tick(Q);
  endtask

  task automatic doStop();
    sdaDrv = 1'b0; tick(Q); sclDrv = 1'b1; tick(Q); sdaDrv = 1'b1; tick(Q);
  endtask

  task automatic sendBits(input logic [7:0] b, input int n, input bit glitch);
    for (int i = 0; i < n; i++) begin
      sdaDrv = b[7-i];
      if (glitch) begin
        tick(3); sclDrv = 1'b1; tick(2); sclDrv = 1'b0; tick(5);
        sclDrv = 1'b1; tick(8);
        if (b[7-i]) begin sdaDrv = 1'b0; tick(2); sdaDrv = 1'b1; tick(10); end
        else tick(12);
      end else begin
        tick(Q); sclDrv = 1'b1; tick(2*Q);
      end
      sclDrv = 1'b0; tick(Q);
    end
  endtask

  task automatic sendByte(input logic [7:0] b, input bit glitch, output bit acked);
    sendBits(b, 8, glitch);
    sdaDrv = 1'b1; tick(Q); sclDrv = 1'b1; tick(Q);
    acked = (sdaLine == 1'b0);
    tick(Q); sclDrv = 1'b0; tick(Q);
  endtask

  task automatic recvByte(output logic [7:0] b, input bit ackIt);
    sdaDrv = 1'b1;
    for (int i = 0; i < 8; i++) begin
      tick(Q); sclDrv = 1'b1; tick(Q);
      b[7-i] = sdaLine;
      tick(Q); sclDrv = 1'b0;
    end
    tick(2); sdaDrv = ackIt ? 1'b0 : 1'b1; tick(Q);
    sclDrv = 1'b1; tick(2*Q); sclDrv = 1'b0; tick(2); sdaDrv = 1'b1; tick(Q);
  endtask

  task automatic writeTx(input int idx, input int cnt, input logic [7:0] dat [8],
                         input int n, input bit glitch, input string tag);
    bit a;
    int expIdx [$];
    cmpEn = 1'b0; strobeQ.delete();
    doStart();
    sendByte(8'hD2, 1'b0, a); chk(a, {tag, " write address ack"}, a, 1);
    sendByte(8'(idx), 1'b0, a); chk(a, {tag, " index ack"}, a, 1);
    sendByte(8'(cnt), 1'b0, a); chk(a, {tag, " count ack"}, a, 1);
    for (int k = 0; k < n; k++) begin
      sendByte(dat[k], glitch, a); chk(a, {tag, " data ack"}, a, 1);
      if (k < cnt && idx + k < NR) begin
        expRegs[idx+k] = (idx + k == 10) ? (int'(dat[k]) & 8'hDF) : int'(dat[k]);
        expIdx.push_back(idx + k);
      end
    end
    doStop(); tick(10);
    chk(sdaPullLow == 1'b0, "R9 released after stop", sdaPullLow, 0);
    chk(strobeQ.size() == expIdx.size(), {tag, " strobe count"}, strobeQ.size(), expIdx.size());
    for (int k = 0; k < expIdx.size() && k < strobeQ.size(); k++)
      chk(strobeQ[k] == expIdx[k], {tag, " strobe index"}, strobeQ[k], expIdx[k]);
    cmpEn = 1'b1;
  endtask

  task automatic readTx(input int idx, input int n);
    bit a;
    logic [7:0] b;
    doStart();
    sendByte(8'hD2, 1'b0, a); chk(a, "R2 write address ack", a, 1);
    sendByte(8'(idx), 1'b0, a); chk(a, "R6 index ack", a, 1);
    doStart();
    sendByte(8'hD3, 1'b0, a); chk(a, "R2 read address ack", a, 1);
    recvByte(b, 1'b1); chk(int'(b) == expRegs[8], "R6 count byte first", b, expRegs[8]);
    for (int k = 0; k < n; k++) begin
      int e = (idx + k < NR) ? expRegs[idx+k] : 8'hFF;
      recvByte(b, k < n - 1);
      chk(int'(b) == e, (idx + k < NR) ? "R6 read data" : "R7 read past end", b, e);
    end
    doStop(); tick(10);
  endtask

  initial begin
    logic [7:0] d [8];
    bit a;
    for (int i = 0; i < NR; i++) expRegs[i] = 0;
    expRegs[1] = 8'hFF; expRegs[2] = 8'hFF; expRegs[8] = 8'h0F; expRegs[9] = 8'h07;
    tick(5); rstN = 1'b1; tick(5);
    // R1 reset contents
    chk(cfgRegs[1*8 +: 8] == 8'hFF, "R1 reg1", cfgRegs[1*8 +: 8], 8'hFF);
    chk(cfgRegs[2*8 +: 8] == 8'hFF, "R1 reg2", cfgRegs[2*8 +: 8], 8'hFF);
    chk(cfgRegs[8*8 +: 8] == 8'h0F, "R1 reg8", cfgRegs[8*8 +: 8], 8'h0F);
    chk(cfgRegs[9*8 +: 8] == 8'h07, "R1 reg9", cfgRegs[9*8 +: 8], 8'h07);
    chk(cfgRegs[10*8 +: 8] == 8'h00, "R1 reg10", cfgRegs[10*8 +: 8], 0);
    chk(cfgRegs[0 +: 8] == 8'h00, "R1 reg0", cfgRegs[0 +: 8], 0);
    chk(sdaPullLow == 1'b0, "R9 idle after reset", sdaPullLow, 0);
    cmpEn = 1'b1;

    // R2 foreign address is not acknowledged
    strobeQ.delete();
    doStart(); sendByte(8'hA4, 1'b0, a); chk(!a, "R2 foreign address nack", a, 0);
    sendByte(8'h03, 1'b0, a); chk(!a, "R2 rest ignored", a, 0);
    doStop(); tick(10);
    chk(strobeQ.size() == 0, "R2 no strobes", strobeQ.size(), 0);

    d = '{8'h11, 8'h22, 8'h33, 8'h44, 0, 0, 0, 0};
    writeTx(3, 4, d, 4, 1'b0, "R3");
    d = '{8'hAA, 8'hBB, 8'hCC, 8'hDD, 8'hEE, 0, 0, 0};
    writeTx(0, 2, d, 5, 1'b0, "R4");
    d = '{8'h01, 8'h02, 8'h03, 8'h04, 0, 0, 0, 0};
    writeTx(13, 4, d, 4, 1'b0, "R5");
    d = '{8'hFF, 0, 0, 0, 0, 0, 0, 0};
    writeTx(10, 1, d, 1, 1'b0, "R8");
    chk(cfgRegs[10*8 +: 8] == 8'hDF, "R8 alarm bit stays 0", cfgRegs[10*8 +: 8], 8'hDF);

    readTx(3, 3);
    d = '{8'h05, 0, 0, 0, 0, 0, 0, 0};
    writeTx(8, 1, d, 1, 1'b0, "R6");
    readTx(0, 2);
    readTx(13, 4);

    // R10 glitches on both lines inside the data byte
    d = '{8'h5A, 0, 0, 0, 0, 0, 0, 0};
    writeTx(4, 1, d, 1, 1'b1, "R10");
    chk(cfgRegs[4*8 +: 8] == 8'h5A, "R10 glitched byte", cfgRegs[4*8 +: 8], 8'h5A);

    // R11 start partway through a byte
    cmpEn = 1'b0; strobeQ.delete();
    doStart();
    sendByte(8'hD2, 1'b0, a); sendByte(8'h05, 1'b0, a); sendByte(8'h02, 1'b0, a);
    sendBits(8'h77, 4, 1'b0);
    doStart();
    sendByte(8'hD2, 1'b0, a); chk(a, "R11 address after abort", a, 1);
    sendByte(8'h06, 1'b0, a); sendByte(8'h01, 1'b0, a); sendByte(8'h99, 1'b0, a);
    doStop(); tick(10);
    expRegs[6] = 8'h99;
    chk(strobeQ.size() == 1, "R11 only resent byte stored", strobeQ.size(), 1);
    chk(cfgRegs[5*8 +: 8] == 8'h33, "R11 reg5 untouched", cfgRegs[5*8 +: 8], 8'h33);
    cmpEn = 1'b1;

    // R11 stop partway through a byte, then bytes without start
    strobeQ.delete();
    doStart();
    sendByte(8'hD2, 1'b0, a); sendByte(8'h00, 1'b0, a); sendByte(8'h01, 1'b0, a);
    sendBits(8'h3C, 3, 1'b0);
    doStop(); tick(Q);
    sclDrv = 1'b0; tick(Q);
    sendByte(8'hD2, 1'b0, a); chk(!a, "R11 ignored without start", a, 0);
    sendByte(8'h00, 1'b0, a); chk(!a, "R11 ignored without start", a, 0);
    sclDrv = 1'b1; tick(Q); doStop(); tick(10);
    chk(strobeQ.size() == 0, "R11 no strobes after stop", strobeQ.size(), 0);
    chk(cfgRegs[0 +: 8] == 8'hAA, "R11 reg0 untouched", cfgRegs[0 +: 8], 8'hAA);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule